// File: doc/BRIEF.md
# Bundle-Redundant NAND Gate with Threshold Decoder

This block computes a two-input NAND in a way that tolerates faulty gates. Each logical operand arrives as a bundle of N parallel wires that should all carry the same value. An executive stage holds N NAND copies. Each copy combines one line of the first bundle with a line of the second bundle, and a fixed wiring permutation picks that second line. The resulting bundle then passes through a configurable number of restorative pairs. Each pass in a pair NANDs the bundle against a rotated copy of itself. A single pass inverts the signal, so passes are always used in pairs. A pair turns a minority of wrong lines back into agreement with the majority.

A decoder counts how many output lines are high. It compares that count against an integer threshold `thr`, which stands for a fraction δ of the bundle with 0 < δ < ½. The result is a three-way verdict: logic one, logic zero or undecided.

Every NAND copy of every stage has its own fault controls, so errors can be injected on purpose. The outputs are registered by default, and a valid flag travels alongside them.

Top module: `nandmux_gate`

## Requirements
- R1: With no faults, executive copy i drives `~(in_a[i] & in_b[(EXE_MUL*i + EXE_OFF) mod N])`. The defaults are N=8, EXE_MUL=3 and EXE_OFF=1.
- R2: Restorative pass k (k = 0 … 2·RPAIRS−1, run in order) drives copy i as `~(x[i] & x[(i + (k mod (N−1)) + 1) mod N])`, where x is the previous stage's bundle. With the default RPAIRS=1 there are two passes.
- R3: With no faults and unanimous inputs, the output bundle is unanimous and equals the NAND of the two input values (all-ones inputs give 0x00, and an all-zero input gives 0xFF).
- R4: With RPAIRS=0, the output bundle is the raw executive bundle.
- R5: Fault controls are indexed by bit s·N+i, for stage s (0 = executive, then restorative passes in order) and copy i. When `flt_en` is set, the copy's output is inverted if `flt_flip` is 1. Otherwise the copy is held at `flt_lvl`.
- R6: `out_count` equals the number of high lines in `out_bundle`.
- R7: `out_status` is 2'b01 (one) when `out_count > N − thr`.
- R8: `out_status` is 2'b00 (zero) when `out_count < thr`.
- R9: Otherwise `out_status` is 2'b10 (undecided). This includes `thr = 0`. The code 2'b11 never appears.
- R10: Outputs show the inputs of the previous clock cycle, and `out_valid` is `in_valid` delayed by one cycle.
- R11: Synchronous reset clears `out_valid`, `out_bundle` and `out_count`, and sets `out_status` to undecided.
- R12: With RPAIRS ≥ 1 and unanimous inputs, a single flipped executive copy is fully corrected at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bundles are meaningful |
| in_a | input | N | First operand bundle |
| in_b | input | N | Second operand bundle |
| thr | input | CW | Decoder threshold count δ·N |
| flt_en | input | NSTG·N | Per-copy fault enable |
| flt_flip | input | NSTG·N | Fault kind: 1 inverts, 0 holds at level |
| flt_lvl | input | NSTG·N | Held level for non-inverting faults |
| out_valid | output | 1 | Delayed `in_valid` |
| out_bundle | output | N | Final bundle after restoration |
| out_count | output | CW | Number of high output lines |
| out_status | output | 2 | 00 zero, 01 one, 10 undecided |

## Verification
The hardest situation to reach is a count that lands between the two thresholds. The restorative pairs are designed to push any input toward a unanimous bundle, so an undecided count rarely arises from the operands alone. The stimulus reaches that band by holding several copies of the final pass at fixed levels. It also reaches it by setting a zero threshold, and by layering sparse random faults across all stages. A second instance with no restorative pairs shows the raw executive bundle. This makes it visible that an injected executive error really occurred before restoration hid it.

// File: rtl/nandmux_pkg.sv
package nandmux_pkg;
  typedef enum logic [1:0] {
    ST_ZERO  = 2'b00,
    ST_ONE   = 2'b01,
    ST_UNDEC = 2'b10
  } verdict_e;
endpackage

// File: rtl/nandmux_stage.sv
// One bank of N NAND copies; operand b reaches copy i through a fixed
// stride/offset permutation. Each copy has its own fault override.
module nandmux_stage #(
  parameter int N    = 8,
  parameter int PMUL = 1,
  parameter int POFF = 1
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] f_en,
  input  logic [N-1:0] f_flip,
  input  logic [N-1:0] f_lvl,
  output logic [N-1:0] y
);
  logic [N-1:0] raw;

  for (genvar i = 0; i < N; i++) begin : g_copy
    localparam int J = (i * PMUL + POFF) % N;
    assign raw[i] = ~(a[i] & b[J]);
    assign y[i]   = f_en[i] ? (f_flip[i] ? ~raw[i] : f_lvl[i]) : raw[i];
  end
endmodule

// File: rtl/nandmux_popcount.sv
module nandmux_popcount #(
  parameter int N  = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  v,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(v[i]);
  end
endmodule

// File: rtl/nandmux_classify.sv
// Counts stimulated lines and sorts the count into one / zero / undecided.
module nandmux_classify
  import nandmux_pkg::*;
#(
  parameter int N  = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bundle,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] cnt,
  output logic [1:0]    verdict
);
  logic [CW:0] sum_ct;
  logic        hi_hit, lo_hit;

  nandmux_popcount #(.N(N)) u_pop (.v(bundle), .cnt(cnt));

  // count > N - thr is evaluated as count + thr > N to avoid underflow
  assign sum_ct = {1'b0, cnt} + {1'b0, thr};
  assign hi_hit = sum_ct > (CW + 1)'(N);
  assign lo_hit = cnt < thr;

  always_comb begin
    if (hi_hit)      verdict = ST_ONE;
    else if (lo_hit) verdict = ST_ZERO;
    else             verdict = ST_UNDEC;
  end
endmodule

// File: rtl/nandmux_gate.sv
module nandmux_gate
  import nandmux_pkg::*;
#(
  parameter int N       = 8,
  parameter int RPAIRS  = 1,
  parameter int EXE_MUL = 3,
  parameter int EXE_OFF = 1,
  parameter bit REG_OUT = 1'b1,
  localparam int NSTG   = 1 + 2 * RPAIRS,
  localparam int FW     = NSTG * N,
  localparam int CW     = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [N-1:0]  in_a,
  input  logic [N-1:0]  in_b,
  input  logic [CW-1:0] thr,
  input  logic [FW-1:0] flt_en,
  input  logic [FW-1:0] flt_flip,
  input  logic [FW-1:0] flt_lvl,
  output logic          out_valid,
  output logic [N-1:0]  out_bundle,
  output logic [CW-1:0] out_count,
  output logic [1:0]    out_status
);
  logic [N-1:0]  stg [NSTG];
  logic [CW-1:0] cnt_c;
  logic [1:0]    verdict_c;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_exe
      nandmux_stage #(.N(N), .PMUL(EXE_MUL), .POFF(EXE_OFF)) u_exe (
        .a(in_a), .b(in_b),
        .f_en(flt_en[s*N +: N]), .f_flip(flt_flip[s*N +: N]),
        .f_lvl(flt_lvl[s*N +: N]), .y(stg[s])
      );
    end else begin : g_res
      localparam int ROT = ((s - 1) % (N - 1)) + 1;
      nandmux_stage #(.N(N), .PMUL(1), .POFF(ROT)) u_res (
        .a(stg[s-1]), .b(stg[s-1]),
        .f_en(flt_en[s*N +: N]), .f_flip(flt_flip[s*N +: N]),
        .f_lvl(flt_lvl[s*N +: N]), .y(stg[s])
      );
    end
  end

  nandmux_classify #(.N(N)) u_cls (
    .bundle(stg[NSTG-1]), .thr(thr), .cnt(cnt_c), .verdict(verdict_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= 1'b0;
        out_bundle <= '0;
        out_count  <= '0;
        out_status <= ST_UNDEC;
      end else begin
        out_valid  <= in_valid;
        out_bundle <= stg[NSTG-1];
        out_count  <= cnt_c;
        out_status <= verdict_c;
      end
    end

    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_unan_high_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (&in_a) && (&in_b) && !(|flt_en)) |=> (out_bundle == '0));

    assert_unan_low_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !(|in_a) && !(|in_b) && !(|flt_en)) |=> (&out_bundle));

    assert_count_match_R6: assert property (@(posedge clk) disable iff (rst)
      out_count == CW'($countones(out_bundle)));

    assert_clean_one_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !(|in_a) && !(|flt_en) && (thr != '0) &&
       ({1'b0, thr} < (CW + 1)'((N + 1) / 2))) |=> (out_status == ST_ONE));

    assert_no_bad_code_R9: assert property (@(posedge clk) disable iff (rst)
      out_status != 2'b11);
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign out_bundle = stg[NSTG-1];
    assign out_count  = cnt_c;
    assign out_status = verdict_c;
  end
endmodule

// File: tb/nandmux_gate_tb.sv
module nandmux_gate_tb;
  localparam int N  = 8;
  localparam int RP = 1;
  localparam int NS = 1 + 2 * RP;
  localparam int FW = NS * N;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  in_a = '0, in_b = '0;
  logic [CW-1:0] thr = '0;
  logic [FW-1:0] flt_en = '0, flt_flip = '0, flt_lvl = '0;

  logic          out_valid, raw_valid;
  logic [N-1:0]  out_bundle, raw_bundle;
  logic [CW-1:0] out_count, raw_count;
  logic [1:0]    out_status, raw_status;

  int compared = 0;
  int mismatched = 0;
  bit have_exp = 0;
  logic          exp_v;
  logic [N-1:0]  exp_b, exp_rb;
  int            exp_c, exp_rc, exp_s, exp_rs;

  always #10ns clk = ~clk;

  nandmux_gate #(.N(N), .RPAIRS(RP)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .thr(thr), .flt_en(flt_en), .flt_flip(flt_flip), .flt_lvl(flt_lvl),
    .out_valid(out_valid), .out_bundle(out_bundle), .out_count(out_count),
    .out_status(out_status)
  );

  nandmux_gate #(.N(N), .RPAIRS(0)) u_raw (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .thr(thr), .flt_en(flt_en[N-1:0]), .flt_flip(flt_flip[N-1:0]),
    .flt_lvl(flt_lvl[N-1:0]), .out_valid(raw_valid), .out_bundle(raw_bundle),
    .out_count(raw_count), .out_status(raw_status)
  );

  function automatic logic apply_fault(logic v, int s, int i, logic [FW-1:0] e,
                                       logic [FW-1:0] f, logic [FW-1:0] l);
    int k = s * N + i;
    if (!e[k]) return v;
    return f[k] ? ~v : l[k];
  endfunction

  function automatic logic [N-1:0] model_bundle(logic [N-1:0] a, logic [N-1:0] b,
      logic [FW-1:0] e, logic [FW-1:0] f, logic [FW-1:0] l, int passes);
    logic [N-1:0] x, y;
    for (int i = 0; i < N; i++)
      x[i] = apply_fault(~(a[i] & b[(3 * i + 1) % N]), 0, i, e, f, l);
    for (int k = 0; k < passes; k++) begin
      for (int i = 0; i < N; i++)
        y[i] = apply_fault(~(x[i] & x[(i + (k % (N - 1)) + 1) % N]), k + 1, i, e, f, l);
      x = y;
    end
    return x;
  endfunction

  function automatic int ones(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int verdict(int c, int t);
    if (c > N - t) return 1;
    if (c < t) return 0;
    return 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R10 out_valid", int'(out_valid), int'(exp_v));
    chk("R1 R2 R5 bundle", int'(out_bundle), int'(exp_b));
    chk("R6 count", int'(out_count), exp_c);
    chk("R7 R8 R9 status", int'(out_status), exp_s);
    chk("R4 raw bundle", int'(raw_bundle), int'(exp_rb));
    chk("R6 raw count", int'(raw_count), exp_rc);
    chk("R7 R8 R9 raw status", int'(raw_status), exp_rs);
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] b, input int t,
                      input logic [FW-1:0] e, input logic [FW-1:0] f,
                      input logic [FW-1:0] l, input logic v);
    @(negedge clk);
    if (have_exp) compare_all();
    in_a = a; in_b = b; thr = CW'(t); flt_en = e; flt_flip = f; flt_lvl = l;
    in_valid = v;
    exp_v  = v;
    exp_b  = model_bundle(a, b, e, f, l, 2 * RP);
    exp_c  = ones(exp_b);
    exp_s  = verdict(exp_c, t);
    exp_rb = model_bundle(a, b, e, f, l, 0);
    exp_rc = ones(exp_rb);
    exp_rs = verdict(exp_rc, t);
    have_exp = 1;
  endtask

  // wait one edge with inputs held, then inspect outputs directly
  task automatic peek();
    @(negedge clk);
  endtask

  task automatic reset_check(input string tag);
    chk({tag, " R11 valid"}, int'(out_valid), 0);
    chk({tag, " R11 bundle"}, int'(out_bundle), 0);
    chk({tag, " R11 count"}, int'(out_count), 0);
    chk({tag, " R11 status"}, int'(out_status), 2);
  endtask

  initial begin
    #4ms;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_check("init");
    rst = 1'b0;

    // R3 / R8: unanimous ones give an all-zero bundle, verdict zero
    step('1, '1, 2, '0, '0, '0, 1'b1);
    peek();
    chk("R3 all-ones in", int'(out_bundle), 0);
    chk("R8 zero verdict", int'(out_status), 0);

    // R3 / R7 / R4: unanimous zeros give all-ones everywhere
    step('0, '0, 2, '0, '0, '0, 1'b1);
    peek();
    chk("R3 all-zero in", int'(out_bundle), 8'hFF);
    chk("R7 one verdict", int'(out_status), 1);
    chk("R4 raw all-zero in", int'(raw_bundle), 8'hFF);

    // R1: mixed operands through the executive permutation
    step(8'hA5, 8'h3C, 3, '0, '0, '0, 1'b1);
    step(8'hF0, 8'h0F, 1, '0, '0, '0, 1'b1);

    // R12: one flipped executive copy; raw shows it, restored output does not
    step('1, '1, 2, FW'(1) << 3, FW'(1) << 3, '0, 1'b1);
    peek();
    chk("R12 restored bundle", int'(out_bundle), 0);
    chk("R4 raw shows flip", int'(raw_bundle), 8'h08);

    // R5: last-pass copy 5 held high
    step('1, '1, 2, FW'(1) << (2 * N + 5), '0, FW'(1) << (2 * N + 5), 1'b1);
    peek();
    chk("R5 stuck copy", int'(out_bundle), 8'h20);
    chk("R8 one stray line", int'(out_status), 0);

    // R9: four last-pass copies held high -> count in the middle band
    step('1, '1, 2, FW'(8'h0F) << (2 * N), '0, FW'(8'h0F) << (2 * N), 1'b1);
    peek();
    chk("R9 middle band", int'(out_status), 2);

    // R9: zero threshold never decides
    step('0, '0, 0, '0, '0, '0, 1'b1);
    peek();
    chk("R9 zero threshold", int'(out_status), 2);

    // R10: invalid input cycle
    step(8'h11, 8'h22, 2, '0, '0, '0, 1'b0);
    peek();
    chk("R10 valid low", int'(out_valid), 0);

    // mixed stimulus with sparse faults in every stage
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0]  a, b;
      logic [FW-1:0] e, f, l;
      int t;
      a = N'($urandom); b = N'($urandom);
      if (n % 4 == 0) a = '1;
      if (n % 4 == 1) begin a = '0; b = '0; end
      if (n % 4 == 2) b = '1;
      e = FW'($urandom) & FW'($urandom) & FW'($urandom);
      f = FW'($urandom); l = FW'($urandom);
      t = $urandom_range(0, 3);
      step(a, b, t, e, f, l, ($urandom_range(0, 7) != 0));
    end

    // R11: synchronous reset in mid-run
    @(negedge clk);
    compare_all();
    have_exp = 0;
    rst = 1'b1;
    @(negedge clk);
    reset_check("mid");
    rst = 1'b0;
    step(8'h5A, 8'hC3, 2, '0, '0, '0, 1'b1);
    step('0, '0, 2, '0, '0, '0, 1'b0);
    @(negedge clk);
    compare_all();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule